// File: doc/BRIEF.md
# Isochronous Transmit Double-Bank Packet Buffer

This block stages outgoing data for an isochronous USB endpoint in two equal packet banks. At any moment one bank belongs to the CPU, which fills it one byte at a time through a write-only 8-bit port. The other bank belongs to the USB side, which pulls the bytes of the committed packet out in order. The CPU does not start a transfer. Each start-of-frame pulse turns the bytes written so far into one packet, and at the same time the two banks trade roles. The packet length is the number of bytes the CPU wrote. A frame with no writes yields a zero-length packet.

The USB side sees a byte-valid flag, the byte at the current read position, a marker on the final byte, and an empty flag when the committed packet has no bytes. A start-of-frame can arrive after the USB side has taken at least one byte but before it has taken the final byte. In that case the swap is postponed until the final byte is taken. During the wait the packet being committed is frozen. Two clears are available. One empties both banks. The other empties only the CPU bank and leaves the committed packet untouched. Writes beyond one bank's capacity are dropped and raise a sticky overflow flag.

A swap controller has two states. C_FILL is normal operation. From C_FILL, a start-of-frame swaps at once, or moves to C_HOLD if the USB side is streaming. C_HOLD waits. It swaps and returns to C_FILL when streaming ends, and it returns to C_FILL without a swap on a full clear. The USB read port has four states:

| State | Meaning |
|---|---|
| U_EMPTY | No bytes, or a zero-length packet |
| U_AVAIL | Packet loaded, nothing read yet |
| U_STREAM | At least one byte read, final byte not yet read |
| U_DONE | All bytes read |

The read port moves between these states as follows:

- A load goes to U_EMPTY when the length is zero and to U_AVAIL otherwise.
- U_AVAIL goes to U_STREAM on a read, or straight to U_DONE for a one-byte packet.
- U_STREAM goes to U_DONE when the final byte is read.
- A full clear returns the port to U_EMPTY from any state.

Top module: `iso_tx_pingpong`

## Requirements
- R1: After reset, usb_empty is 1, usb_valid is 0 and wr_overflow is 0.
- R2: Each accepted CPU write stores its byte at the next position of the CPU bank. On a sof pulse, the accepted writes form a packet whose length equals their count. A write in the same cycle as sof belongs to that packet. The packet is presented from the cycle after sof.
- R3: usb_valid is 1 while unread bytes remain, and usb_data is the byte at the read position. usb_rd while valid advances the position by one. usb_last is 1 exactly on the final byte. After the final byte is read, usb_valid and usb_empty are both 0.
- R4: A sof with no accepted writes commits a zero-length packet. usb_empty becomes 1 and usb_valid stays 0.
- R5: Writes beyond 64 bytes into one bank are ignored, and the packet keeps 64 bytes. Such a write sets wr_overflow, which stays 1 until either clear.
- R6: Once a packet is committed, CPU writes go to the other bank and do not change the presented packet. The next sof presents the newly written bytes.
- R7: clr_all empties both banks. usb_empty is 1 from the next cycle, a following sof with no writes commits a zero-length packet, and wr_overflow clears.
- R8: clr_cpu empties only the CPU bank and clears wr_overflow. The committed packet stays fully readable.
- R9: A sof that arrives after at least one byte of the current packet has been read, but before its final byte, leaves the current packet in place. The swap happens in the cycle after the final byte is read. CPU writes made while the swap waits are ignored.
- R10: A clear beats a write in the same cycle. clr_cpu in the same cycle as sof commits a zero-length packet.
- R11: A sof while the presented packet is unread, or fully read, replaces it at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | CPU write strobe |
| cpu_wr_data | input | 8 | CPU write byte |
| sof | input | 1 | Start-of-frame pulse |
| clr_all | input | 1 | Empty both banks |
| clr_cpu | input | 1 | Empty the CPU bank only |
| usb_rd | input | 1 | USB side takes the current byte |
| usb_data | output | 8 | Byte at the read position |
| usb_valid | output | 1 | usb_data holds an unread byte |
| usb_last | output | 1 | Current byte is the packet's final byte |
| usb_empty | output | 1 | Committed packet has zero length |
| wr_overflow | output | 1 | Sticky: a write hit a full bank |

## Verification
The assertions check a set of invariants on every cycle:

- The write count stays within one bank.
- Overflow stays sticky between clears.
- The read position stays below the packet length while valid.
- Valid and empty never coincide.
- Every swap flips bank ownership.
- Ownership is held while a deferred swap waits.
- A full clear yields an empty port.

Byte contents and order, packet lengths, the last-byte marker, and the isolation between the two banks can only be shown by the bench scenarios. The same applies to the exact cycle on which a deferred swap completes and to the different reach of the two clears.

// File: rtl/iso_tx_pkg.sv
package iso_tx_pkg;

    typedef enum logic [1:0] {
        U_EMPTY  = 2'd0,
        U_AVAIL  = 2'd1,
        U_STREAM = 2'd2,
        U_DONE   = 2'd3
    } rd_state_t;

    typedef enum logic {
        C_FILL = 1'b0,
        C_HOLD = 1'b1
    } sw_state_t;

endpackage

// File: rtl/iso_tx_bank_store.sv
module iso_tx_bank_store #(
    parameter int PKT_BYTES = 64,
    parameter int DW        = 8,
    localparam int AW       = $clog2(PKT_BYTES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          we_bank,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_bank,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] bank_out [2];

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [DW-1:0] mem [PKT_BYTES];

        always_ff @(posedge clk) begin
            if (we && (we_bank == 1'(g))) begin
                mem[waddr] <= wdata;
            end
        end

        assign bank_out[g] = mem[raddr];
    end

    assign rdata = bank_out[rd_bank];

endmodule

// File: rtl/iso_tx_wr_port.sv
module iso_tx_wr_port #(
    parameter int PKT_BYTES = 64,
    parameter int DW        = 8,
    localparam int AW       = $clog2(PKT_BYTES),
    localparam int CW       = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          block,
    input  logic          clr_all,
    input  logic          clr_cpu,
    input  logic          swap,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [CW-1:0] cnt_nxt,
    output logic          ovf
);

    localparam logic [CW-1:0] FULL = CW'(PKT_BYTES);

    logic [CW-1:0] cnt_q;
    logic          any_clr;
    logic          accept;
    logic          reject_full;

    assign any_clr     = clr_all || clr_cpu;
    assign accept      = wr_en && !block && !any_clr && (cnt_q < FULL);
    assign reject_full = wr_en && !block && !any_clr && (cnt_q == FULL);

    always_comb begin
        if (any_clr) begin
            cnt_nxt = '0;
        end else if (accept) begin
            cnt_nxt = CW'(cnt_q + 1'b1);
        end else begin
            cnt_nxt = cnt_q;
        end
    end

    assign mem_we    = accept;
    assign mem_addr  = cnt_q[AW-1:0];
    assign mem_wdata = wr_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (swap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (any_clr) begin
            ovf <= 1'b0;
        end else if (reject_full) begin
            ovf <= 1'b1;
        end
    end

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);

    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr_all && !clr_cpu) |=> ovf);

endmodule

// File: rtl/iso_tx_rd_port.sv
module iso_tx_rd_port
    import iso_tx_pkg::*;
#(
    parameter int PKT_BYTES = 64,
    localparam int AW       = $clog2(PKT_BYTES),
    localparam int CW       = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_len,
    input  logic          flush,
    input  logic          rd,
    output logic [AW-1:0] rd_addr,
    output logic          valid,
    output logic          last,
    output logic          empty,
    output logic          streaming
);

    rd_state_t     state_q;
    rd_state_t     state_d;
    logic [CW-1:0] ptr_q;
    logic [CW-1:0] len_q;
    logic          take;

    assign take = rd && valid;

    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = U_EMPTY;
        end else if (load) begin
            state_d = (load_len == '0) ? U_EMPTY : U_AVAIL;
        end else begin
            unique case (state_q)
                U_AVAIL: begin
                    if (take) begin
                        state_d = last ? U_DONE : U_STREAM;
                    end
                end
                U_STREAM: begin
                    if (take && last) begin
                        state_d = U_DONE;
                    end
                end
                U_EMPTY, U_DONE: begin
                    state_d = state_q;
                end
                default: state_d = U_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= U_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            len_q <= '0;
        end else if (flush) begin
            ptr_q <= '0;
            len_q <= '0;
        end else if (load) begin
            ptr_q <= '0;
            len_q <= load_len;
        end else if (take) begin
            ptr_q <= CW'(ptr_q + 1'b1);
        end
    end

    always_comb begin
        valid     = (state_q == U_AVAIL) || (state_q == U_STREAM);
        streaming = (state_q == U_STREAM);
        empty     = (state_q == U_EMPTY);
        last      = valid && (ptr_q == CW'(len_q - 1'b1));
        rd_addr   = ptr_q[AW-1:0];
    end

    assert_ptr_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (ptr_q < len_q));

    assert_valid_excl_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && empty));

    assert_last_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && last && !load && !flush) |=> (!valid && !empty));

endmodule

// File: rtl/iso_tx_swap_ctrl.sv
module iso_tx_swap_ctrl
    import iso_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sof,
    input  logic clr_all,
    input  logic usb_streaming,
    output logic swap,
    output logic block,
    output logic cpu_bank
);

    sw_state_t st_q;
    sw_state_t st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            C_FILL: begin
                if (!clr_all && sof && usb_streaming) begin
                    st_d = C_HOLD;
                end
            end
            C_HOLD: begin
                if (clr_all || !usb_streaming) begin
                    st_d = C_FILL;
                end
            end
            default: st_d = C_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= C_FILL;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        swap  = 1'b0;
        block = 1'b0;
        unique case (st_q)
            C_FILL: swap = sof && !usb_streaming && !clr_all;
            C_HOLD: begin
                block = 1'b1;
                swap  = !usb_streaming && !clr_all;
            end
            default: swap = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_bank <= 1'b0;
        end else if (swap) begin
            cpu_bank <= ~cpu_bank;
        end
    end

    assert_swap_flips_R6: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> (cpu_bank != $past(cpu_bank)));

    assert_hold_keeps_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == C_HOLD && usb_streaming) |=> $stable(cpu_bank));

endmodule

// File: rtl/iso_tx_pingpong.sv
module iso_tx_pingpong #(
    parameter int PKT_BYTES = 64,
    parameter int DW        = 8,
    localparam int AW       = $clog2(PKT_BYTES),
    localparam int CW       = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_wr_en,
    input  logic [DW-1:0] cpu_wr_data,
    input  logic          sof,
    input  logic          clr_all,
    input  logic          clr_cpu,
    input  logic          usb_rd,
    output logic [DW-1:0] usb_data,
    output logic          usb_valid,
    output logic          usb_last,
    output logic          usb_empty,
    output logic          wr_overflow
);

    logic          swap;
    logic          block;
    logic          cpu_bank;
    logic          streaming;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [CW-1:0] cnt_nxt;
    logic [AW-1:0] rd_addr;

    iso_tx_swap_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .sof           (sof),
        .clr_all       (clr_all),
        .usb_streaming (streaming),
        .swap          (swap),
        .block         (block),
        .cpu_bank      (cpu_bank)
    );

    iso_tx_wr_port #(.PKT_BYTES(PKT_BYTES), .DW(DW)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cpu_wr_en),
        .wr_data   (cpu_wr_data),
        .block     (block),
        .clr_all   (clr_all),
        .clr_cpu   (clr_cpu),
        .swap      (swap),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .cnt_nxt   (cnt_nxt),
        .ovf       (wr_overflow)
    );

    iso_tx_bank_store #(.PKT_BYTES(PKT_BYTES), .DW(DW)) u_store (
        .clk     (clk),
        .we      (mem_we),
        .we_bank (cpu_bank),
        .waddr   (mem_addr),
        .wdata   (mem_wdata),
        .rd_bank (~cpu_bank),
        .raddr   (rd_addr),
        .rdata   (usb_data)
    );

    iso_tx_rd_port #(.PKT_BYTES(PKT_BYTES)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (swap),
        .load_len  (cnt_nxt),
        .flush     (clr_all),
        .rd        (usb_rd),
        .rd_addr   (rd_addr),
        .valid     (usb_valid),
        .last      (usb_last),
        .empty     (usb_empty),
        .streaming (streaming)
    );

    assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (usb_empty && !usb_valid && !wr_overflow));

endmodule

// File: tb/iso_tx_pingpong_test.sv
module iso_tx_pingpong_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr_en = 1'b0;
    logic [7:0] cpu_wr_data = '0;
    logic       sof = 1'b0;
    logic       clr_all = 1'b0;
    logic       clr_cpu = 1'b0;
    logic       usb_rd = 1'b0;
    logic [7:0] usb_data;
    logic       usb_valid;
    logic       usb_last;
    logic       usb_empty;
    logic       wr_overflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    iso_tx_pingpong uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_wr_en   (cpu_wr_en),
        .cpu_wr_data (cpu_wr_data),
        .sof         (sof),
        .clr_all     (clr_all),
        .clr_cpu     (clr_cpu),
        .usb_rd      (usb_rd),
        .usb_data    (usb_data),
        .usb_valid   (usb_valid),
        .usb_last    (usb_last),
        .usb_empty   (usb_empty),
        .wr_overflow (wr_overflow)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_bytes(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            cpu_wr_en   = 1'b1;
            cpu_wr_data = 8'(base + i);
            tick();
        end
        cpu_wr_en = 1'b0;
    endtask

    task automatic pulse_sof();
        sof = 1'b1;
        tick();
        sof = 1'b0;
    endtask

    task automatic read_check(input string tag, input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            chk({tag, " valid"}, usb_valid, 1);
            chk({tag, " data"}, usb_data, 8'(base + i));
            chk({tag, " last"}, usb_last, (i == n - 1) ? 1 : 0);
            usb_rd = 1'b1;
            tick();
            usb_rd = 1'b0;
        end
        chk({tag, " valid after end"}, usb_valid, 0);
        chk({tag, " empty after end"}, usb_empty, 0);
    endtask

    task automatic t_reset();
        chk("R1 empty", usb_empty, 1);
        chk("R1 valid", usb_valid, 0);
        chk("R1 overflow", wr_overflow, 0);
    endtask

    task automatic t_basic();
        write_bytes(4, 8'h10);
        cpu_wr_en = 1'b1; cpu_wr_data = 8'h14; sof = 1'b1;
        tick();
        cpu_wr_en = 1'b0; sof = 1'b0;
        chk("R2 empty", usb_empty, 0);
        read_check("R2 R3 packet", 5, 8'h10);
    endtask

    task automatic t_zero();
        pulse_sof();
        chk("R4 empty", usb_empty, 1);
        chk("R4 valid", usb_valid, 0);
    endtask

    task automatic t_overflow();
        write_bytes(64, 8'h40);
        chk("R5 no overflow at 64", wr_overflow, 0);
        write_bytes(2, 8'hF0);
        chk("R5 overflow set", wr_overflow, 1);
        pulse_sof();
        read_check("R5 capped packet", 64, 8'h40);
        chk("R5 overflow sticky", wr_overflow, 1);
        clr_cpu = 1'b1; tick(); clr_cpu = 1'b0;
        chk("R5 R8 overflow cleared", wr_overflow, 0);
    endtask

    task automatic t_pingpong();
        write_bytes(3, 8'hA0);
        pulse_sof();
        write_bytes(4, 8'hB0);
        chk("R6 presented data kept", usb_data, 8'hA0);
        read_check("R6 first packet", 3, 8'hA0);
        pulse_sof();
        read_check("R6 second packet", 4, 8'hB0);
    endtask

    task automatic t_clear_all();
        write_bytes(4, 8'h20);
        pulse_sof();
        write_bytes(2, 8'h30);
        clr_all = 1'b1; tick(); clr_all = 1'b0;
        chk("R7 empty after clear", usb_empty, 1);
        chk("R7 valid after clear", usb_valid, 0);
        pulse_sof();
        chk("R7 cpu bank emptied", usb_empty, 1);
    endtask

    task automatic t_clear_cpu();
        write_bytes(3, 8'hC0);
        pulse_sof();
        write_bytes(5, 8'hD0);
        clr_cpu = 1'b1; tick(); clr_cpu = 1'b0;
        read_check("R8 committed intact", 3, 8'hC0);
        pulse_sof();
        chk("R8 cpu bank emptied", usb_empty, 1);
    endtask

    task automatic t_deferred();
        write_bytes(4, 8'h50);
        pulse_sof();
        write_bytes(3, 8'h60);
        chk("R9 first byte", usb_data, 8'h50);
        usb_rd = 1'b1; tick(); usb_rd = 1'b0;
        pulse_sof();
        write_bytes(1, 8'hEE);
        chk("R9 old packet held", usb_data, 8'h51);
        read_check("R9 old packet tail", 3, 8'h51);
        tick();
        chk("R9 swap after last", usb_valid, 1);
        read_check("R9 new packet", 3, 8'h60);
    endtask

    task automatic t_priority();
        write_bytes(2, 8'h90);
        sof = 1'b1; clr_cpu = 1'b1; cpu_wr_en = 1'b1; cpu_wr_data = 8'h92;
        tick();
        sof = 1'b0; clr_cpu = 1'b0; cpu_wr_en = 1'b0;
        chk("R10 clear with sof gives empty", usb_empty, 1);
        chk("R10 no valid", usb_valid, 0);
    endtask

    task automatic t_replace();
        write_bytes(2, 8'h70);
        pulse_sof();
        write_bytes(3, 8'h80);
        pulse_sof();
        read_check("R11 replaced packet", 3, 8'h80);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_basic();
        t_zero();
        t_overflow();
        t_pingpong();
        t_clear_all();
        t_clear_cpu();
        t_deferred();
        t_priority();
        t_replace();
        finish_run();
    end

endmodule